// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block picks the address of the next instruction for a 32-bit RISC core. Each cycle it takes the current PC, a decoded control-transfer kind and the operands that kind may need: two register values for a compare, a signed 16-bit branch offset, a 26-bit direct-call field and the value of the return-address register. On the next clock edge it presents the next PC, a flag saying whether control left the sequential path, and a request to write the return address into register 31.

Conditional branches compare the two register operands as signed or unsigned values. Greater-than and less-or-equal forms are handled upstream by swapping the operands. Direct calls keep the top four bits of the current PC and replace the rest with the 26-bit field shifted left by two, so one call reaches anywhere in a 256-MB window. Register-indirect forms take a full 32-bit target from a register operand. All results pass through one register stage that an active-low asynchronous reset clears.

Top module: `nextpc_unit`

## Requirements
- R1: While rst_ni is low, npc_o equals RESET_PC (default 0), and taken_o and link_we_o are 0. This holds without a clock edge.
- R2: Outputs appear one clock edge after their inputs. For xfer_i=0 (sequential), npc_o=pc_i+4 with 32-bit wraparound, taken_o=0 and link_we_o=0.
- R3: For xfer_i=1 (conditional branch), cond_i=0 is a signed less-than of opa_i against opb_i, and cond_i=2 is a signed greater-or-equal.
- R4: cond_i=1 is the unsigned less-than and cond_i=3 is the unsigned greater-or-equal. For operands that are equal, greater-or-equal is true.
- R5: cond_i=4 is taken when opa_i equals opb_i, and cond_i=5 is taken when they differ.
- R6: A taken conditional branch gives npc_o=pc_i+4+sign_extend(ofs_i), and taken_o=1. A branch that is not taken gives npc_o=pc_i+4 and taken_o=0. Neither case writes a link.
- R7: xfer_i=2 (unconditional branch) is always taken, goes to the same offset target as R6, and writes no link.
- R8: xfer_i=3 (direct call) gives npc_o={pc_i[31:28], tgt_i, 2'b00}, taken_o=1 and link_we_o=1, with link_data_o=pc_i+4 and link_idx_o=31.
- R9: xfer_i=4 (call via register) and xfer_i=5 (jump via register) both go to opa_i and set taken_o=1. Only xfer_i=4 writes the link (pc_i+4 into register 31).
- R10: xfer_i=6 (return) goes to ra_i, sets taken_o=1 and writes no link.
- R11: Bits [1:0] of npc_o are always 0, whatever the operand, offset or register target.
- R12: xfer_i=7 behaves as sequential. A conditional branch with cond_i of 6 or 7 is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current PC |
| xfer_i | input | 3 | Transfer kind: 0 seq, 1 cond branch, 2 branch, 3 call, 4 call reg, 5 jump reg, 6 return |
| cond_i | input | 3 | Branch condition: 0 lt, 1 ltu, 2 ge, 3 geu, 4 eq, 5 ne |
| opa_i | input | 32 | First compare operand, also the register target |
| opb_i | input | 32 | Second compare operand |
| ofs_i | input | 16 | Signed byte offset from PC+4 |
| tgt_i | input | 26 | Direct-call word target field |
| ra_i | input | 32 | Current return-address register value |
| npc_o | output | 32 | Next PC, word aligned |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Write return address request |
| link_idx_o | output | 5 | Register index for the link write (31) |
| link_data_o | output | 32 | Return address (PC+4) |

## Verification
The compare conditions are tried with the operand pair -1 and 1, where the signed and unsigned answers disagree, and with equal operands, where less-than and greater-or-equal must split and equal and not-equal must flip. Branch targets are checked with small positive offsets, the most negative offset and an offset with its low bits set. Direct calls are checked at both extremes of the 26-bit field and with different top PC bits. Register targets are given misaligned values to check the alignment of npc_o. Reserved transfer and condition codes, PC wraparound, and a reset asserted mid-run between clock edges complete the set.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [2:0] {
    XF_SEQ   = 3'd0,
    XF_BCOND = 3'd1,
    XF_BR    = 3'd2,
    XF_CALL  = 3'd3,
    XF_CALLR = 3'd4,
    XF_JMPR  = 3'd5,
    XF_RET   = 3'd6,
    XF_RSVD  = 3'd7
  } xfer_e;

  typedef enum logic [2:0] {
    CC_LT  = 3'd0,
    CC_LTU = 3'd1,
    CC_GE  = 3'd2,
    CC_GEU = 3'd3,
    CC_EQ  = 3'd4,
    CC_NE  = 3'd5,
    CC_R6  = 3'd6,
    CC_R7  = 3'd7
  } cond_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cond_e            cond_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  output logic             hit_o
);
  logic lt_s, lt_u, eq;

  assign lt_s = $signed(opa_i) < $signed(opb_i);
  assign lt_u = opa_i < opb_i;
  assign eq   = opa_i == opb_i;

  always_comb begin
    unique case (cond_i)
      CC_LT:   hit_o = lt_s;
      CC_LTU:  hit_o = lt_u;
      CC_GE:   hit_o = !lt_s;
      CC_GEU:  hit_o = !lt_u;
      CC_EQ:   hit_o = eq;
      CC_NE:   hit_o = !eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned IMM_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [IMM_W-1:0] tgt_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  rel_o,
  output logic [XLEN-1:0]  abs_o
);
  localparam int unsigned HI_W = XLEN - IMM_W - 2;
  localparam int unsigned EXT_W = XLEN - OFS_W;

  logic [XLEN-1:0] ofs_ext;

  assign seq_o   = pc_i + XLEN'(INSN_BYTES);
  assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign rel_o   = seq_o + ofs_ext;

  generate
    if (HI_W > 0) begin : g_region
      assign abs_o = {pc_i[XLEN-1 -: HI_W], tgt_i, 2'b00};
    end else begin : g_flat
      assign abs_o = {tgt_i[XLEN-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int unsigned    XLEN     = 32,
  parameter int unsigned    OFS_W    = 16,
  parameter int unsigned    IMM_W    = 26,
  parameter int unsigned    REG_W    = 5,
  parameter int unsigned    LINK_REG = 31,
  parameter logic [31:0]    RESET_PC = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [2:0]       xfer_i,
  input  logic [2:0]       cond_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [IMM_W-1:0] tgt_i,
  input  logic [XLEN-1:0]  ra_i,
  output logic [XLEN-1:0]  npc_o,
  output logic             taken_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_data_o
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(INSN_BYTES - 1);

  xfer_e           xfer;
  cond_e           cond;
  logic            hit;
  logic [XLEN-1:0] seq_pc, rel_pc, abs_pc;
  logic [XLEN-1:0] nxt_pc;
  logic            nxt_taken, nxt_link;

  assign xfer = xfer_e'(xfer_i);
  assign cond = cond_e'(cond_i);

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .cond_i (cond),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .hit_o  (hit)
  );

  nextpc_target #(.XLEN(XLEN), .OFS_W(OFS_W), .IMM_W(IMM_W)) u_tgt (
    .pc_i  (pc_i),
    .ofs_i (ofs_i),
    .tgt_i (tgt_i),
    .seq_o (seq_pc),
    .rel_o (rel_pc),
    .abs_o (abs_pc)
  );

  always_comb begin
    nxt_pc    = seq_pc;
    nxt_taken = 1'b0;
    nxt_link  = 1'b0;
    unique case (xfer)
      XF_BCOND: if (hit) begin
        nxt_pc    = rel_pc;
        nxt_taken = 1'b1;
      end
      XF_BR: begin
        nxt_pc    = rel_pc;
        nxt_taken = 1'b1;
      end
      XF_CALL: begin
        nxt_pc    = abs_pc;
        nxt_taken = 1'b1;
        nxt_link  = 1'b1;
      end
      XF_CALLR: begin
        nxt_pc    = opa_i;
        nxt_taken = 1'b1;
        nxt_link  = 1'b1;
      end
      XF_JMPR: begin
        nxt_pc    = opa_i;
        nxt_taken = 1'b1;
      end
      XF_RET: begin
        nxt_pc    = ra_i;
        nxt_taken = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      npc_o       <= RESET_PC[XLEN-1:0] & ALIGN_MASK;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      npc_o       <= nxt_pc & ALIGN_MASK;
      taken_o     <= nxt_taken;
      link_we_o   <= nxt_link;
      link_data_o <= seq_pc;
    end
  end

  assign link_idx_o = REG_W'(LINK_REG);
endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned IMM_W = 26,
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  pc_i,
  input logic [2:0]       xfer_i,
  input logic [2:0]       cond_i,
  input logic [XLEN-1:0]  opa_i,
  input logic [XLEN-1:0]  opb_i,
  input logic [IMM_W-1:0] tgt_i,
  input logic [XLEN-1:0]  ra_i,
  input logic [XLEN-1:0]  npc_o,
  input logic             taken_o,
  input logic             link_we_o,
  input logic [REG_W-1:0] link_idx_o,
  input logic [XLEN-1:0]  link_data_o
);
  a_r2_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd0) |=> (npc_o == (($past(pc_i) + 32'd4) & ~32'd3)) && !taken_o && !link_we_o);

  a_r5_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd1 && cond_i == 3'd4) |=> (taken_o == ($past(opa_i) == $past(opb_i))));

  a_r7_br_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd2) |=> taken_o && !link_we_o);

  a_r8_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd3) |=> link_we_o && link_idx_o == 5'd31
      && link_data_o == $past(pc_i) + 32'd4
      && npc_o == {$past(pc_i[31:28]), $past(tgt_i), 2'b00});

  a_r9_jmpr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd5) |=> taken_o && !link_we_o && npc_o == ($past(opa_i) & ~32'd3));

  a_r10_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd6) |=> taken_o && !link_we_o && npc_o == ($past(ra_i) & ~32'd3));

  a_r11_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc_o[1:0] == 2'b00);

  a_r12_rsvd_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == 3'd1 && cond_i[2:1] == 2'b11) |=> !taken_o);
endmodule

bind nextpc_unit nextpc_chk #(.XLEN(XLEN), .OFS_W(OFS_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .xfer_i      (xfer_i),
  .cond_i      (cond_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .tgt_i       (tgt_i),
  .ra_i        (ra_i),
  .npc_o       (npc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_idx_o  (link_idx_o),
  .link_data_o (link_data_o)
);

// File: tb/sim_nextpc_unit.sv
`timescale 1ns/1ps
module sim_nextpc_unit;
  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  xfer;
    logic [2:0]  cond;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] ofs;
    logic [25:0] t26;
    logic [31:0] ra;
    logic [31:0] npc;
    logic        tk;
    logic        we;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  3'd0, 3'd0, 32'h1000_0100, 32'h0,         32'h0, 16'h0000, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R2
    '{8'd3,  3'd1, 3'd0, 32'h1000_0100, 32'hFFFF_FFFF, 32'h1, 16'h0010, 26'h0,       32'h0,         32'h1000_0114, 1'b1, 1'b0}, // R3 lt
    '{8'd4,  3'd1, 3'd1, 32'h1000_0100, 32'hFFFF_FFFF, 32'h1, 16'h0010, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R4 ltu
    '{8'd3,  3'd1, 3'd2, 32'h1000_0100, 32'hFFFF_FFFF, 32'h1, 16'h0010, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R3 ge
    '{8'd4,  3'd1, 3'd3, 32'h1000_0100, 32'hFFFF_FFFF, 32'h1, 16'hFFF0, 26'h0,       32'h0,         32'h1000_00F4, 1'b1, 1'b0}, // R4 geu
    '{8'd5,  3'd1, 3'd4, 32'h1000_0100, 32'h5,         32'h5, 16'h0008, 26'h0,       32'h0,         32'h1000_010C, 1'b1, 1'b0}, // R5 eq
    '{8'd5,  3'd1, 3'd5, 32'h1000_0100, 32'h5,         32'h5, 16'h0008, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R5 ne
    '{8'd6,  3'd1, 3'd5, 32'h1000_0100, 32'h5,         32'h6, 16'h8000, 26'h0,       32'h0,         32'h0FFF_8104, 1'b1, 1'b0}, // R6
    '{8'd7,  3'd2, 3'd6, 32'h1000_0100, 32'h0,         32'h0, 16'h0020, 26'h0,       32'h0,         32'h1000_0124, 1'b1, 1'b0}, // R7
    '{8'd8,  3'd3, 3'd0, 32'hA000_0100, 32'h0,         32'h0, 16'h0000, 26'h3FF_FFFF, 32'h0,        32'hAFFF_FFFC, 1'b1, 1'b1}, // R8
    '{8'd8,  3'd3, 3'd0, 32'h5000_0000, 32'h0,         32'h0, 16'h0000, 26'h000_0001, 32'h0,        32'h5000_0004, 1'b1, 1'b1}, // R8
    '{8'd9,  3'd4, 3'd0, 32'h1000_0100, 32'h1234_5677, 32'h0, 16'h0000, 26'h0,       32'h0,         32'h1234_5674, 1'b1, 1'b1}, // R9 callr
    '{8'd9,  3'd5, 3'd0, 32'h1000_0100, 32'h0000_2002, 32'h0, 16'h0000, 26'h0,       32'h0,         32'h0000_2000, 1'b1, 1'b0}, // R9 jmpr
    '{8'd10, 3'd6, 3'd0, 32'h1000_0100, 32'h0,         32'h0, 16'h0000, 26'h0,       32'h0000_4003, 32'h0000_4000, 1'b1, 1'b0}, // R10
    '{8'd12, 3'd7, 3'd0, 32'h1000_0100, 32'h0,         32'h0, 16'h0040, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R12 xfer
    '{8'd12, 3'd1, 3'd6, 32'h1000_0100, 32'h7,         32'h7, 16'h0040, 26'h0,       32'h0,         32'h1000_0104, 1'b0, 1'b0}, // R12 cond
    '{8'd2,  3'd0, 3'd0, 32'hFFFF_FFFC, 32'h0,         32'h0, 16'h0000, 26'h0,       32'h0,         32'h0000_0000, 1'b0, 1'b0}, // R2 wrap
    '{8'd11, 3'd1, 3'd4, 32'h1000_0100, 32'h9,         32'h9, 16'h0003, 26'h0,       32'h0,         32'h1000_0104, 1'b1, 1'b0}, // R11
    '{8'd4,  3'd1, 3'd3, 32'h1000_0100, 32'h9,         32'h9, 16'h0004, 26'h0,       32'h0,         32'h1000_0108, 1'b1, 1'b0}  // R4 geu equal
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0, ra_i = '0;
  logic [2:0]  xfer_i = '0, cond_i = '0;
  logic [15:0] ofs_i = '0;
  logic [25:0] tgt_i = '0;
  logic [31:0] npc_o, link_data_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  nextpc_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .xfer_i(xfer_i), .cond_i(cond_i),
    .opa_i(opa_i), .opb_i(opb_i), .ofs_i(ofs_i), .tgt_i(tgt_i), .ra_i(ra_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_idx_o(link_idx_o), .link_data_o(link_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #5;
    // R1 reset state
    chk("R1 npc", npc_o, 32'h0);
    chk("R1 taken", {31'b0, taken_o}, 32'h0);
    chk("R1 we", {31'b0, link_we_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xfer_i = VECS[i].xfer; cond_i = VECS[i].cond; pc_i = VECS[i].pc;
      opa_i = VECS[i].a; opb_i = VECS[i].b; ofs_i = VECS[i].ofs;
      tgt_i = VECS[i].t26; ra_i = VECS[i].ra;
      @(negedge clk_i);
      chk($sformatf("R%0d npc v%0d", VECS[i].req, i), npc_o, VECS[i].npc);
      chk($sformatf("R%0d taken v%0d", VECS[i].req, i), {31'b0, taken_o}, {31'b0, VECS[i].tk});
      chk($sformatf("R%0d link_we v%0d", VECS[i].req, i), {31'b0, link_we_o}, {31'b0, VECS[i].we});
      if (VECS[i].we) begin
        chk($sformatf("R%0d link_data v%0d", VECS[i].req, i), link_data_o, VECS[i].pc + 32'd4);
        chk($sformatf("R%0d link_idx v%0d", VECS[i].req, i), {27'b0, link_idx_o}, 32'd31);
      end
      chk($sformatf("R11 align v%0d", i), {30'b0, npc_o[1:0]}, 32'h0);
    end

    // R8 call then async reset between edges clears outputs (R1)
    xfer_i = 3'd3; pc_i = 32'h3000_0000; tgt_i = 26'h000_0010;
    @(negedge clk_i);
    chk("R8 call npc", npc_o, 32'h3000_0040);
    #3 rst_ni = 1'b0;
    #1;
    chk("R1 async npc", npc_o, 32'h0);
    chk("R1 async we", {31'b0, link_we_o}, 32'h0);
    chk("R1 async taken", {31'b0, taken_o}, 32'h0);
    @(negedge clk_i);
    chk("R1 held npc", npc_o, 32'h0);
    rst_ni = 1'b1;
    xfer_i = 3'd0; pc_i = 32'h0000_0010;
    @(negedge clk_i);
    chk("R2 after reset", npc_o, 32'h0000_0014);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule